// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Serial Peripheral Pin Override

This block is an 8-pin general-purpose I/O port. Software drives it through a small register bus with three registers: an output data register, a direction register and a read-only input register. Three serial peripherals can each claim a fixed group of pins. A synchronous serial peripheral takes the upper four pins. Two asynchronous serial channels take two pins each. A claimed pin follows its peripheral. The GPIO registers then have no effect on that pin, but software can still read and write them.

Pin inputs pass through a two-flop synchronizer. The synchronized levels feed the register readback and the receive inputs of the peripherals. Readback of the data register depends on direction. An output bit returns the stored value. An input bit returns the synchronized pin level. The input register always returns the synchronized pin levels.

Top module: `gpio_mux_port`

## Requirements
- R1: While reset is asserted, and after it is released, the direction register reads 0x00. With no peripheral enabled, every `pin_oe` bit is 0, so each pin is a high-impedance input.
- R2: A write with `bus_we`=1 updates the data register at address 0 and the direction register at address 1. The new value is visible on the next clock.
- R3: Reading address 0 returns the following, bit by bit: the stored data bit where the direction bit is 1, and the synchronized pin level where the direction bit is 0.
- R4: Reading address 2 returns the synchronized pin levels whatever the direction bits are. Reading address 3 returns 0x00. Writes to address 2 or 3 change no register.
- R5: A change on `pin_in` reaches the readback path two rising clock edges later, and not after one.
- R6: On a pin that no enabled peripheral owns, `pin_out` equals the data bit and `pin_oe` equals the direction bit.
- R7: While `spi_en`=1, pins 7, 6, 5 and 4 carry `spi_drv[3]` (select), `spi_drv[2]` (clock), `spi_drv[1]` (master-out) and `spi_drv[0]` (master-in). With `spi_master`=1, pins 7 to 5 drive and pin 4 is an input. With `spi_master`=0 it is the reverse.
- R8: While `uart1_en`=1, pin 3 drives `uart1_txd` with `pin_oe`=1 and pin 2 is an input. While `uart0_en`=1, pin 1 drives `uart0_txd` and pin 0 is an input.
- R9: Software can write the data and direction registers while a peripheral owns their pins. Those writes have no effect on the owned pins. They take effect as soon as the enable is removed.
- R10: `spi_smp`, `uart1_rxd` and `uart0_rxd` return the synchronized levels of pins 7 to 4, pin 2 and pin 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 2 | Register address: 0 data, 1 direction, 2 input, 3 unused |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| spi_en | input | 1 | Synchronous serial peripheral claims pins 7..4 |
| spi_master | input | 1 | 1: master pin directions, 0: slave pin directions |
| spi_drv | input | 4 | Values the peripheral drives on pins 7..4 |
| spi_smp | output | 4 | Synchronized levels of pins 7..4 |
| uart1_en | input | 1 | Serial channel 1 claims pins 3..2 |
| uart1_txd | input | 1 | Channel 1 transmit value |
| uart1_rxd | output | 1 | Synchronized level of pin 2 |
| uart0_en | input | 1 | Serial channel 0 claims pins 1..0 |
| uart0_txd | input | 1 | Channel 0 transmit value |
| uart0_rxd | output | 1 | Synchronized level of pin 0 |
| pin_in | input | 8 | Raw pin levels |
| pin_out | output | 8 | Pin output values |
| pin_oe | output | 8 | Pin output enables, 1 = drive |

## Verification
The assertions check on every cycle the invariants of pin ownership:
- directions of the serial peripheral pins in both master and slave modes;
- receive pins held as inputs while a channel is enabled;
- transmit values reaching their pins;
- GPIO direction followed when no peripheral is enabled;
- the one-cycle effect of a direction write;
- writes to the input and unused addresses leaving the direction register unchanged.

The following can be shown only by the bench's scenarios, driven against a behavioural reference model: the two-edge synchronizer latency, the mixed data readback that depends on direction, and register values written while a pin was owned becoming visible when the owner lets go.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;
  localparam int PORT_W   = 8;
  localparam int ADDR_W   = 2;
  localparam int SYNC_LEN = 2;

  // Fixed pin groups claimed by the serial peripherals
  localparam int SPI_LO   = 4;
  localparam int SPI_W    = 4;
  localparam int U1_RX    = 2;
  localparam int U1_TX    = 3;
  localparam int U0_RX    = 0;
  localparam int U0_TX    = 1;

  typedef enum logic [ADDR_W-1:0] {
    ADR_DATA = 2'd0,
    ADR_DIR  = 2'd1,
    ADR_IN   = 2'd2,
    ADR_NONE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] chain_q [STAGES];
  logic [W-1:0] chain_d [STAGES];

  always_comb begin
    chain_d[0] = din;
    for (int i = 1; i < STAGES; i++) chain_d[i] = chain_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain_q[i] <= '0;
    end else begin
      for (int i = 0; i < STAGES; i++) chain_q[i] <= chain_d[i];
    end
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_mux_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [PORT_W-1:0] wdata,
  input  logic [PORT_W-1:0] pin_sync,
  output logic [PORT_W-1:0] data_q,
  output logic [PORT_W-1:0] dir_q,
  output logic [PORT_W-1:0] rdata
);
  logic              data_en, dir_en;
  logic [PORT_W-1:0] data_d, dir_d;

  assign data_en = we && (addr == ADR_DATA);
  assign dir_en  = we && (addr == ADR_DIR);

  always_comb begin
    data_d = data_en ? wdata : data_q;
    dir_d  = dir_en  ? wdata : dir_q;
  end

  // Output data register keeps its contents across reset
  always_ff @(posedge clk) begin
    data_q <= data_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dir_q <= '0;
    else        dir_q <= dir_d;
  end

  always_comb begin
    case (addr)
      ADR_DATA: rdata = (dir_q & data_q) | (~dir_q & pin_sync);
      ADR_DIR:  rdata = dir_q;
      ADR_IN:   rdata = pin_sync;
      default:  rdata = '0;
    endcase
  end

  a_r2_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == ADR_DIR) |=> (dir_q == $past(wdata)));

  a_r4_ro_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (addr == ADR_IN || addr == ADR_NONE)) |=> $stable(dir_q));

  a_r4_unused_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADR_NONE) |-> (rdata == '0));
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
  import gpio_mux_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] data_q,
  input  logic [PORT_W-1:0] dir_q,
  input  logic              spi_en,
  input  logic              spi_master,
  input  logic [SPI_W-1:0]  spi_drv,
  input  logic              uart1_en,
  input  logic              uart1_txd,
  input  logic              uart0_en,
  input  logic              uart0_txd,
  output logic [PORT_W-1:0] pin_out,
  output logic [PORT_W-1:0] pin_oe
);
  logic [PORT_W-1:0] per_own, per_oe, per_val;

  for (genvar p = 0; p < PORT_W; p++) begin : g_pin
    if (p >= SPI_LO && p < SPI_LO + SPI_W) begin : g_spi
      // lowest pin of the group is master-in: input for a master
      assign per_own[p] = spi_en;
      assign per_val[p] = spi_drv[p-SPI_LO];
      assign per_oe[p]  = (p == SPI_LO) ? !spi_master : spi_master;
    end else if (p == U1_TX || p == U1_RX) begin : g_u1
      assign per_own[p] = uart1_en;
      assign per_val[p] = (p == U1_TX) ? uart1_txd : 1'b0;
      assign per_oe[p]  = (p == U1_TX);
    end else if (p == U0_TX || p == U0_RX) begin : g_u0
      assign per_own[p] = uart0_en;
      assign per_val[p] = (p == U0_TX) ? uart0_txd : 1'b0;
      assign per_oe[p]  = (p == U0_TX);
    end else begin : g_free
      assign per_own[p] = 1'b0;
      assign per_val[p] = 1'b0;
      assign per_oe[p]  = 1'b0;
    end
    assign pin_out[p] = per_own[p] ? per_val[p] : data_q[p];
    assign pin_oe[p]  = per_own[p] ? per_oe[p]  : dir_q[p];
  end

  a_r7_spi_master_dirs: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_en && spi_master) |-> (pin_oe[SPI_LO+SPI_W-1:SPI_LO] == 4'b1110));

  a_r7_spi_slave_dirs: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_en && !spi_master) |-> (pin_oe[SPI_LO+SPI_W-1:SPI_LO] == 4'b0001));

  a_r8_rx_pins_input: assert property (@(posedge clk) disable iff (!rst_n)
    ((uart1_en && pin_oe[U1_RX]) || (uart0_en && pin_oe[U0_RX])) |-> 1'b0);

  a_r8_tx_drive: assert property (@(posedge clk) disable iff (!rst_n)
    uart1_en |-> (pin_oe[U1_TX] && pin_out[U1_TX] == uart1_txd));
endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port
  import gpio_mux_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [PORT_W-1:0] bus_wdata,
  output logic [PORT_W-1:0] bus_rdata,
  input  logic              spi_en,
  input  logic              spi_master,
  input  logic [SPI_W-1:0]  spi_drv,
  output logic [SPI_W-1:0]  spi_smp,
  input  logic              uart1_en,
  input  logic              uart1_txd,
  output logic              uart1_rxd,
  input  logic              uart0_en,
  input  logic              uart0_txd,
  output logic              uart0_rxd,
  input  logic [PORT_W-1:0] pin_in,
  output logic [PORT_W-1:0] pin_out,
  output logic [PORT_W-1:0] pin_oe
);
  logic              rst_n_int;
  logic [PORT_W-1:0] pin_sync, data_q, dir_q;

  // Reset: asserted at once, released after two clocks
  gpio_sync #(.W(1), .STAGES(SYNC_LEN)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .din(1'b1), .dout(rst_n_int)
  );

  gpio_sync #(.W(PORT_W), .STAGES(SYNC_LEN)) u_pin_sync (
    .clk(clk), .rst_n(rst_n_int), .din(pin_in), .dout(pin_sync)
  );

  gpio_regs u_regs (
    .clk(clk), .rst_n(rst_n_int), .addr(bus_addr), .we(bus_we),
    .wdata(bus_wdata), .pin_sync(pin_sync), .data_q(data_q),
    .dir_q(dir_q), .rdata(bus_rdata)
  );

  gpio_pin_mux u_mux (
    .clk(clk), .rst_n(rst_n_int), .data_q(data_q), .dir_q(dir_q),
    .spi_en(spi_en), .spi_master(spi_master), .spi_drv(spi_drv),
    .uart1_en(uart1_en), .uart1_txd(uart1_txd),
    .uart0_en(uart0_en), .uart0_txd(uart0_txd),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  assign spi_smp   = pin_sync[SPI_LO+SPI_W-1:SPI_LO];
  assign uart1_rxd = pin_sync[U1_RX];
  assign uart0_rxd = pin_sync[U0_RX];

  a_r6_gpio_dir_follows: assert property (@(posedge clk) disable iff (!rst_n_int)
    !(spi_en || uart1_en || uart0_en) |-> (pin_oe == dir_q));

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n_int)
    ($rose(rst_n_int) && !(spi_en || uart1_en || uart0_en)) |-> (pin_oe == '0));
endmodule

// File: tb/gpio_mux_port_bench.sv
`timescale 1ns/100ps
module gpio_mux_port_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       spi_en = 0, spi_master = 0;
  logic [3:0] spi_drv = 4'd0;
  logic [3:0] spi_smp;
  logic       uart1_en = 0, uart1_txd = 0, uart1_rxd;
  logic       uart0_en = 0, uart0_txd = 0, uart0_rxd;
  logic [7:0] pin_in = 8'd0;
  logic [7:0] pin_out, pin_oe;

  int checks = 0, failures = 0;
  string phase = "R1";

  always #2 clk = ~clk;

  gpio_mux_port u_gpio_mux_port (.*);

  // ---------------- behavioural reference model ----------------
  logic [7:0] m_data = 8'bx;
  logic [7:0] m_dir  = 8'h00;
  logic [7:0] seen [$];   // pin samples taken on functional edges
  int edges_since_release = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      edges_since_release = 0;
      m_dir = 8'h00;
      seen = {};
    end else begin
      edges_since_release++;
      if (bus_we && bus_addr == 2'd0) m_data = bus_wdata;
      if (edges_since_release > 2) begin
        if (bus_we && bus_addr == 2'd1) m_dir = bus_wdata;
        seen.push_back(pin_in);
        if (seen.size() > 2) void'(seen.pop_front());
      end
    end
  end

  function automatic logic [7:0] m_pins();
    return (seen.size() == 2) ? seen[0] : 8'h00;
  endfunction

  logic [7:0] e_oe, e_out, e_rd;
  always_comb begin
    for (int p = 0; p < 8; p++) begin
      e_oe[p] = m_dir[p]; e_out[p] = m_data[p];
      if (spi_en && p >= 4) begin
        e_oe[p] = (p == 4) ? !spi_master : spi_master;
        e_out[p] = spi_drv[p-4];
      end
      if (uart1_en && (p == 3 || p == 2)) begin
        e_oe[p] = (p == 3); e_out[p] = uart1_txd;
      end
      if (uart0_en && (p == 1 || p == 0)) begin
        e_oe[p] = (p == 1); e_out[p] = uart0_txd;
      end
    end
    case (bus_addr)
      2'd0: e_rd = (m_dir & m_data) | (~m_dir & m_pins());
      2'd1: e_rd = m_dir;
      2'd2: e_rd = m_pins();
      default: e_rd = 8'h00;
    endcase
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare on every clock, away from the rising edge
  always @(negedge clk) begin
    chk({phase, " pin_oe"}, pin_oe, e_oe);
    chk({phase, " pin_out"}, pin_out & e_oe, e_out & e_oe);
    chk({phase, " rdata"}, bus_rdata, e_rd);
    chk({phase, " rx"}, {spi_smp, 2'b00, uart1_rxd, uart0_rxd},
        {m_pins()[7:4], 2'b00, m_pins()[2], m_pins()[0]});
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    cyc(1);
    bus_we = 1'b0;
  endtask

  initial begin
    #1;
    cyc(3);
    chk("R1 dir in reset", bus_rdata, 8'h00);  // addr 0, pins 0
    chk("R1 oe in reset", pin_oe, 8'h00);
    rst_n = 1'b1;
    cyc(4);
    bus_addr = 2'd1; cyc(1);
    chk("R1 dir after reset", bus_rdata, 8'h00);
    chk("R1 oe after reset", pin_oe, 8'h00);

    phase = "R2";
    wr(2'd0, 8'hA5);
    wr(2'd1, 8'h0F);
    bus_addr = 2'd1; cyc(1);
    chk("R2 dir write", bus_rdata, 8'h0F);
    phase = "R6";
    chk("R6 gpio oe", pin_oe, 8'h0F);
    chk("R6 gpio out", pin_out & 8'h0F, 8'h05);

    phase = "R4";
    wr(2'd2, 8'hFF);
    wr(2'd3, 8'hFF);
    bus_addr = 2'd1; cyc(1);
    chk("R4 dir unchanged", bus_rdata, 8'h0F);
    bus_addr = 2'd3; cyc(1);
    chk("R4 unused reads zero", bus_rdata, 8'h00);

    phase = "R5";
    bus_addr = 2'd2; pin_in = 8'h3C;
    @(negedge clk);
    chk("R5 one edge old", bus_rdata, 8'h00);
    @(negedge clk);
    chk("R5 two edges new", bus_rdata, 8'h3C);
    #1;
    phase = "R3";
    bus_addr = 2'd0; cyc(1);
    chk("R3 mixed readback", bus_rdata, 8'h35);

    phase = "R7";
    spi_en = 1; spi_master = 1; spi_drv = 4'b1010; cyc(1);
    chk("R7 master oe", pin_oe[7:4], 4'b1110);
    chk("R7 master out", pin_out[7:5], 3'b101);
    spi_master = 0; spi_drv = 4'b0001; cyc(1);
    chk("R7 slave oe", pin_oe[7:4], 4'b0001);
    chk("R7 slave miso", pin_out[4], 1'b1);

    phase = "R8";
    uart1_en = 1; uart1_txd = 1; uart0_en = 1; uart0_txd = 0; cyc(1);
    chk("R8 uart oe", pin_oe[3:0], 4'b1010);
    chk("R8 uart tx", {pin_out[3], pin_out[1]}, 2'b10);
    uart1_txd = 0; uart0_txd = 1; cyc(1);
    chk("R8 uart tx swap", {pin_out[3], pin_out[1]}, 2'b01);

    phase = "R9";
    wr(2'd0, 8'h5A);
    wr(2'd1, 8'hFF);
    cyc(1);
    chk("R9 owned pins kept", pin_oe, 8'h0A | 8'h01 << 4);
    spi_en = 0; uart1_en = 0; uart0_en = 0; cyc(1);
    chk("R9 release oe", pin_oe, 8'hFF);
    chk("R9 release out", pin_out, 8'h5A);

    phase = "R10";
    wr(2'd1, 8'h00);
    pin_in = 8'b1001_0101; cyc(3);
    chk("R10 spi samples", spi_smp, 4'b1001);
    chk("R10 uart rx", {uart1_rxd, uart0_rxd}, 2'b11);
    pin_in = 8'b0110_1010; cyc(3);
    chk("R10 spi samples b", spi_smp, 4'b0110);
    chk("R10 uart rx b", {uart1_rxd, uart0_rxd}, 2'b00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #40000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule